// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through four byte addresses: one data port per channel (addresses 0, 1 and 2) and a shared control port at address 3. Control words written to the control port set each channel's byte access scheme, counting mode and decimal-count flag. They can also capture a channel's running count, or capture status and count for any set of channels in one command.

Count writes on a data port are put together into 16-bit initial counts and handed to the channel's counter with a one-cycle load strobe. Data-port reads return, in order of precedence, a captured status byte, a captured count, or the live count from the counter. Both bytes of a 16-bit value are sequenced through a per-channel byte toggle. The counting logic sits outside this block. It supplies the live count, the OUT level and a pulse that says a written count has been taken into the counter.

Top module: `timer_regif`

## Requirements
- R1: After reset every channel uses two-byte access (low byte then high byte), mode 0, binary counting, has its null-count flag set and holds no captured count or status. A read of address 3 returns 8'h00.
- R2: A control-port write whose bits 7:6 name a channel (0..2) and whose bits 5:4 are nonzero sets that channel's access scheme from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), its mode from bits 3:1 and its decimal flag from bit 0. It resets both byte toggles of that channel to the low byte and sets its null-count flag.
- R3: A mode field of 6 is stored as mode 2, and a mode field of 7 is stored as mode 3.
- R4: In low-byte-only access, a data write loads count {8'h00, byte}. In high-byte-only access, it loads {byte, 8'h00}. The load strobe for the channel and the load value appear on the clock edge that follows the write edge and last one cycle.
- R5: In two-byte access, the first data write only holds the byte and gives no load strobe. The second write loads {second, first}.
- R6: A control word with bits 5:4 = 0 captures the channel's live count. Later data reads return the captured value according to the access scheme that was active at capture: low byte, high byte, or low then high. The capture is then released, and further reads return the live count.
- R7: A control word with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low captures the count and bit 4 low captures the status of each selected channel.
- R8: A count capture request is ignored while a previous count capture is still unread. A status capture request is ignored while a previous status capture is still unread.
- R9: The status byte is {OUT, null-count, access[1:0], mode[2:0], decimal}, from bit 7 down to bit 0. A captured status is returned by the next data read ahead of any captured count and is released by that read.
- R10: In two-byte access with nothing captured, successive data reads alternate between the low and high byte of the live count, starting with the low byte.
- R11: The null-count flag is set by any count load or control word for the channel and is cleared by a pulse on that channel's count-taken input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Byte address: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| cnt_live | input | 48 | Live count of each channel, 16 bits per channel |
| out_live | input | 3 | OUT level of each channel |
| cnt_taken | input | 3 | Pulse per channel: the written count has entered the counter |
| ld_strobe | output | 3 | One-cycle load strobe per channel |
| ld_value | output | 48 | Count to load, 16 bits per channel |
| ch_mode | output | 9 | Stored counting mode, 3 bits per channel |
| ch_bcd | output | 3 | Stored decimal-count flag per channel |

## Verification
Writes are tried in each of the three access schemes, and the two-byte case is cut off halfway by a control word. This shows whether the load value is built from the right bytes and whether a control word clears the pending half. Reads are made with nothing captured, with a count captured, and with status and count captured together. The live count changes between capture and read, so latched data can be told apart from live data and a second capture from the first. Mode codes 6 and 7, OUT toggling between two status captures, and the count-taken pulse show folding, capture persistence and the null-count flag in the status byte.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_PAIR  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e        acc;
        logic [2:0]  mode;
        logic        bcd;
        logic        wr_hi;
        logic [7:0]  wr_hold;
        logic        rd_hi;
        acc_e        lat_cnt;
        logic [15:0] lat_val;
        logic        lat_st;
        logic [7:0]  st_val;
        logic        null_cnt;
        logic        ld;
        logic [15:0] ld_val;
    } chan_state_t;

    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

endpackage

// File: rtl/timer_ctl_decode.sv
module timer_ctl_decode #(
    parameter int NCH = 3
) (
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [NCH-1:0]   cfg_wr,
    output logic [NCH-1:0]   cnt_lat,
    output logic [NCH-1:0]   st_lat,
    output logic [NCH-1:0]   data_wr,
    output logic [NCH-1:0]   data_rd
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic ctrl_wr;
    logic rdbk;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
    assign rdbk    = ctrl_wr && (bus_wdata[7:6] == 2'd3);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_ctl;
        assign sel_ctl    = ctrl_wr && (bus_wdata[7:6] == 2'(i));
        assign cfg_wr[i]  = sel_ctl && (bus_wdata[5:4] != 2'd0);
        assign cnt_lat[i] = (sel_ctl && (bus_wdata[5:4] == 2'd0))
                          || (rdbk && bus_wdata[i+1] && !bus_wdata[5]);
        assign st_lat[i]  = rdbk && bus_wdata[i+1] && !bus_wdata[4];
        assign data_wr[i] = bus_wr && (bus_addr == 2'(i));
        assign data_rd[i] = bus_rd && (bus_addr == 2'(i));
    end
endmodule

// File: rtl/timer_chan_regs.sv
module timer_chan_regs
    import timer_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cnt_lat,
    input  logic        st_lat,
    input  logic        data_wr,
    input  logic        data_rd,
    input  logic [7:0]  wdata,
    input  logic [15:0] live_cnt,
    input  logic        live_out,
    input  logic        cnt_taken,
    output logic [7:0]  rdata,
    output logic        ld_strobe,
    output logic [15:0] ld_value,
    output logic [2:0]  mode,
    output logic        bcd
);
    chan_state_t st_d, st_q;

    always_comb begin
        if (st_q.lat_st)
            rdata = st_q.st_val;
        else if (st_q.lat_cnt == ACC_HI)
            rdata = st_q.lat_val[15:8];
        else if (st_q.lat_cnt != ACC_LATCH)
            rdata = st_q.lat_val[7:0];
        else if (st_q.acc == ACC_HI || (st_q.acc == ACC_PAIR && st_q.rd_hi))
            rdata = live_cnt[15:8];
        else
            rdata = live_cnt[7:0];
    end

    always_comb begin
        st_d    = st_q;
        st_d.ld = 1'b0;

        if (cnt_taken)
            st_d.null_cnt = 1'b0;

        if (cfg_wr) begin
            st_d.acc      = acc_e'(wdata[5:4]);
            st_d.mode     = fold_mode(wdata[3:1]);
            st_d.bcd      = wdata[0];
            st_d.wr_hi    = 1'b0;
            st_d.rd_hi    = 1'b0;
            st_d.null_cnt = 1'b1;
        end

        if (data_rd) begin
            if (st_q.lat_st)
                st_d.lat_st = 1'b0;
            else if (st_q.lat_cnt == ACC_PAIR)
                st_d.lat_cnt = ACC_HI;
            else if (st_q.lat_cnt != ACC_LATCH)
                st_d.lat_cnt = ACC_LATCH;
            else if (st_q.acc == ACC_PAIR)
                st_d.rd_hi = !st_q.rd_hi;
        end

        if (cnt_lat && st_q.lat_cnt == ACC_LATCH) begin
            st_d.lat_cnt = st_q.acc;
            st_d.lat_val = live_cnt;
        end

        if (st_lat && !st_q.lat_st) begin
            st_d.lat_st = 1'b1;
            st_d.st_val = {live_out, st_q.null_cnt, st_q.acc, st_q.mode, st_q.bcd};
        end

        if (data_wr) begin
            unique case (st_q.acc)
                ACC_LO: begin
                    st_d.ld     = 1'b1;
                    st_d.ld_val = {8'h00, wdata};
                end
                ACC_HI: begin
                    st_d.ld     = 1'b1;
                    st_d.ld_val = {wdata, 8'h00};
                end
                ACC_PAIR: begin
                    if (!st_q.wr_hi) begin
                        st_d.wr_hold = wdata;
                        st_d.wr_hi   = 1'b1;
                    end else begin
                        st_d.ld     = 1'b1;
                        st_d.ld_val = {wdata, st_q.wr_hold};
                        st_d.wr_hi  = 1'b0;
                    end
                end
                default: ;
            endcase
            if (st_d.ld)
                st_d.null_cnt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.acc      <= ACC_PAIR;
            st_q.lat_cnt  <= ACC_LATCH;
            st_q.null_cnt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_strobe = st_q.ld;
    assign ld_value  = st_q.ld_val;
    assign mode      = st_q.mode;
    assign bcd       = st_q.bcd;

    // R8
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lat_cnt != ACC_LATCH && !data_rd) |=> $stable(st_q.lat_val));

    // R4
    ld_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ld) |-> $past(data_wr));

    // R9
    st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && st_q.lat_st && !st_lat) |=> !st_q.lat_st);

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode <= 3'd5);
endmodule

// File: rtl/timer_regif.sv
module timer_regif #(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [NCH*CW-1:0] cnt_live,
    input  logic [NCH-1:0]    out_live,
    input  logic [NCH-1:0]    cnt_taken,
    output logic [NCH-1:0]    ld_strobe,
    output logic [NCH*CW-1:0] ld_value,
    output logic [NCH*3-1:0]  ch_mode,
    output logic [NCH-1:0]    ch_bcd
);
    logic [NCH-1:0] cfg_wr, cnt_lat, st_lat, data_wr, data_rd;
    logic [7:0]     ch_rdata [NCH];

    timer_ctl_decode #(.NCH(NCH)) u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg_wr    (cfg_wr),
        .cnt_lat   (cnt_lat),
        .st_lat    (st_lat),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        timer_chan_regs u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_wr[i]),
            .cnt_lat   (cnt_lat[i]),
            .st_lat    (st_lat[i]),
            .data_wr   (data_wr[i]),
            .data_rd   (data_rd[i]),
            .wdata     (bus_wdata),
            .live_cnt  (cnt_live[i*CW +: CW]),
            .live_out  (out_live[i]),
            .cnt_taken (cnt_taken[i]),
            .rdata     (ch_rdata[i]),
            .ld_strobe (ld_strobe[i]),
            .ld_value  (ld_value[i*CW +: CW]),
            .mode      (ch_mode[i*3 +: 3]),
            .bcd       (ch_bcd[i])
        );
    end

    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NCH; i++)
            if (bus_addr == 2'(i))
                bus_rdata = ch_rdata[i];
    end

    // R4
    one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_strobe));
endmodule

// File: tb/timer_regif_bench.sv
module timer_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] cnt_live = '0;
    logic [2:0]  out_live = '0;
    logic [2:0]  cnt_taken = '0;
    logic [2:0]  ld_strobe;
    logic [47:0] ld_value;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    timer_regif u_timer_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cnt_live(cnt_live), .out_live(out_live), .cnt_taken(cnt_taken),
        .ld_strobe(ld_strobe), .ld_value(ld_value), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd3, v);          check("R1 ctrl read", v, 8'h00);
        wr(2'd3, 8'hE2);      // read-back status ch0
        rd(2'd0, v);          check("R1 reset status", v, 8'h70);
    endtask

    task automatic t_fold_and_lsb();
        logic [7:0] v;
        out_live[1] = 1'b1;
        wr(2'd3, 8'h5D);      // ch1, low only, mode 6, decimal
        check("R3 mode fold", ch_mode[5:3], 3'd2);
        wr(2'd3, 8'hE4);
        rd(2'd1, v);          check("R9 status fields", v, 8'hD5);
        wr(2'd1, 8'h34);
        check("R4 lo strobe", ld_strobe, 3'b010);
        check("R4 lo value", ld_value[31:16], 16'h0034);
        @(negedge clk); cnt_taken[1] = 1'b1;
        @(negedge clk); cnt_taken[1] = 1'b0;
        wr(2'd3, 8'hE4);
        rd(2'd1, v);          check("R11 null cleared", v, 8'h95);
        wr(2'd3, 8'h5F);      check("R3 mode 7 fold", ch_mode[5:3], 3'd3);
    endtask

    task automatic t_msb();
        wr(2'd3, 8'hA0);
        wr(2'd2, 8'h12);
        check("R4 hi value", ld_value[47:32], 16'h1200);
        check("R4 hi strobe", ld_strobe, 3'b100);
    endtask

    task automatic t_pair_write();
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h78);      check("R5 no strobe on first byte", ld_strobe, 3'b000);
        wr(2'd0, 8'h56);      check("R5 pair value", ld_value[15:0], 16'h5678);
        wr(2'd0, 8'h99);
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h11);      check("R2 toggle reset on write", ld_strobe, 3'b000);
        wr(2'd0, 8'h22);      check("R2 pair after reset", ld_value[15:0], 16'h2211);
    endtask

    task automatic t_live_reads();
        logic [7:0] v;
        cnt_live[15:0] = 16'hABCD;
        rd(2'd0, v); check("R10 live lo", v, 8'hCD);
        rd(2'd0, v); check("R10 live hi", v, 8'hAB);
        rd(2'd0, v); check("R10 live lo again", v, 8'hCD);
        wr(2'd3, 8'h34);
        rd(2'd0, v); check("R2 read toggle reset", v, 8'hCD);
        wr(2'd3, 8'h34);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        wr(2'd3, 8'h00);
        cnt_live[15:0] = 16'h1111;
        wr(2'd3, 8'h00);      // ignored, capture unread
        cnt_live[15:0] = 16'h1234;
        rd(2'd0, v); check("R6 latched lo", v, 8'hCD);
        rd(2'd0, v); check("R8 latched hi kept", v, 8'hAB);
        rd(2'd0, v); check("R6 live after release", v, 8'h34);
        wr(2'd3, 8'h34);
        cnt_live[47:32] = 16'hBEEF;
        wr(2'd3, 8'h80);
        cnt_live[47:32] = 16'h7700;
        rd(2'd2, v); check("R6 hi-only latched", v, 8'hBE);
        rd(2'd2, v); check("R6 hi-only live", v, 8'h77);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        cnt_live[15:0] = 16'h4321;
        out_live[0] = 1'b0;
        wr(2'd3, 8'hC2);
        cnt_live[15:0] = 16'h0000;
        rd(2'd0, v); check("R9 status first", v, 8'h74);
        rd(2'd0, v); check("R7 count lo", v, 8'h21);
        rd(2'd0, v); check("R7 count hi", v, 8'h43);
        rd(2'd0, v); check("R7 live after", v, 8'h00);
        out_live[1] = 1'b1;
        wr(2'd3, 8'hE4);
        out_live[1] = 1'b0;
        wr(2'd3, 8'hE4);      // ignored, status unread
        rd(2'd1, v); check("R8 status kept", v[7], 1'b1);
        wr(2'd3, 8'hE4);
        rd(2'd1, v); check("R8 status recaptured", v[7], 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 no strobe", ld_strobe, 3'b000);
        check("R1 reset mode", ch_mode, 9'd0);
        t_reset();
        t_fold_and_lsb();
        t_msb();
        t_pair_write();
        t_live_reads();
        t_latch();
        t_readback();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule